// File: doc/BRIEF.md
# Accumulator Execute Unit with Class-Dependent Flags

This block is the execute stage of a small 8-bit accumulator machine. Each cycle it takes one opcode byte, the contents of both accumulators, one register operand already picked by the surrounding datapath, and the present 2-bit flag state. It computes the value to write back to the addressed accumulator, a write strobe, which accumulator is meant, and the next flag state. All four results are registered, so they appear one clock after the inputs are presented.

The two flag bits change meaning with the kind of operation. Arithmetic gives overflow and carry. Bitwise logic gives zero and parity. Shifts give zero and sign. Two operations touch only the flags. One tests the present flag state against a 4-bit mask. The other compares accumulator 0 against accumulator 1 or against zero, under a greater-than and an equal enable. Opcodes that belong to the surrounding machine (jump, load, store, memory) pass through without a write and keep the flags as they are.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are all zero: result 0, write strobe 0, target 0, flags 00.
- R2: Every output is registered. It reflects the inputs sampled at the previous rising edge. When the write strobe is 0, the result and target outputs read 0. When it is 1, the target equals opcode bit 3 (0 means accumulator 0, 1 means accumulator 1).
- R3: Opcodes with bits 7:5 equal to 000 add a 4-bit unsigned immediate to the target accumulator. The immediate is formed as {bit 4, bits 2:0}. Flag bit 1 is the carry out and flag bit 0 is signed overflow.
- R4: Upper nibble 0010 adds the register operand to the target accumulator. Flag bit 1 is the carry out and flag bit 0 is signed overflow.
- R5: Upper nibble 0011 gives accumulator minus operand. Flag bit 1 is 1 exactly when the accumulator is unsigned greater than or equal to the operand (no borrow). Flag bit 0 is signed overflow of the difference.
- R6: Upper nibbles 0111 (XOR), 1100 (AND) and 1101 (OR) combine the accumulator with the operand. Flag bit 0 is 1 when the result is zero. Flag bit 1 is 1 when the result has an odd number of set bits.
- R7: Upper nibbles 1110 and 1111 shift the accumulator logically left and right by the full operand value. A shift amount of 8 or more gives 0. Flag bit 0 is the zero flag and flag bit 1 is result bit 7.
- R8: Upper nibble 0100 leaves the accumulators alone. It sets both flag bits to 1 when opcode bit [n] is 1, where n is the present 2-bit flag value, and clears both otherwise.
- R9: Upper nibble 0101 is a compare that never writes. Bit 3 picks the reference: 1 means accumulator 1, 0 means zero. Accumulator 0 is the left side. Flag bit 1 = (bit 1 and signed greater) or (bit 0 and equal). Flag bit 0 = (bit 1 and unsigned greater) or (bit 0 and equal). Bit 2 is ignored.
- R10: Upper nibbles 0110, 1000, 1001, 1010 and 1011 produce no write and hand the present flag value through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 8 | Opcode byte |
| acc0_i | input | 8 | Accumulator 0 contents |
| acc1_i | input | 8 | Accumulator 1 contents |
| reg_i | input | 8 | Register operand chosen by the opcode's low bits |
| flags_i | input | 2 | Present flag state |
| acc_res_o | output | 8 | Registered value to write back |
| acc_we_o | output | 1 | Registered accumulator write strobe |
| acc_sel_o | output | 1 | Registered target accumulator |
| flags_o | output | 2 | Registered next flag state |

## Verification
The properties assume that every input is a known value at each rising edge once reset is released. They also assume that `reg_i` already holds the register the opcode names. The block cannot check that pairing itself, so the flag-decode and shift-limit properties only read whatever operand is presented. The stimulus changes inputs only on falling edges, keeps every input driven from time zero, and holds reset across the first edges, so no property ever samples an undefined operand or an unreset output.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

  localparam int OP_W   = 8;
  localparam int FLAG_W = 2;
  localparam int IMM_W  = 4;

  typedef enum logic [3:0] {
    K_ADDI,
    K_ADD,
    K_SUB,
    K_XOR,
    K_AND,
    K_OR,
    K_SHL,
    K_SHR,
    K_FDEC,
    K_CMP,
    K_PASS
  } op_kind_e;

endpackage

// File: rtl/acc_exec_decode.sv
module acc_exec_decode
  import acc_exec_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  output op_kind_e         kind,
  output logic             tgt_sel,
  output logic             acc_we,
  output logic [IMM_W-1:0] imm
);

  always_comb begin
    imm     = {op[4], op[2:0]};
    tgt_sel = op[3];
    if (op[7:5] == 3'b000) begin
      kind = K_ADDI;
    end else begin
      unique case (op[7:4])
        4'b0010: kind = K_ADD;
        4'b0011: kind = K_SUB;
        4'b0100: kind = K_FDEC;
        4'b0101: kind = K_CMP;
        4'b0111: kind = K_XOR;
        4'b1100: kind = K_AND;
        4'b1101: kind = K_OR;
        4'b1110: kind = K_SHL;
        4'b1111: kind = K_SHR;
        default: kind = K_PASS;
      endcase
    end
    acc_we = !((kind == K_FDEC) || (kind == K_CMP) || (kind == K_PASS));
  end

endmodule

// File: rtl/acc_exec_arith.sv
module acc_exec_arith #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              ovf
);

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
    sum   = wide[DATA_W-1:0];
    carry = wide[DATA_W];
    ovf   = (a[DATA_W-1] == b_eff[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
  end

endmodule

// File: rtl/acc_exec_bitops.sv
module acc_exec_bitops
  import acc_exec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_kind_e          kind,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);

  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] lst [SH_W+1];
  logic [DATA_W-1:0] rst_ [SH_W+1];
  logic              too_far;

  assign lst[0]  = a;
  assign rst_[0] = a;
  assign too_far = |b[DATA_W-1:SH_W];

  generate
    for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int STEP = 1 << s;
      assign lst[s+1]  = b[s] ? (lst[s]  << STEP) : lst[s];
      assign rst_[s+1] = b[s] ? (rst_[s] >> STEP) : rst_[s];
    end
  endgenerate

  always_comb begin
    unique case (kind)
      K_XOR:   res = a ^ b;
      K_AND:   res = a & b;
      K_OR:    res = a | b;
      K_SHL:   res = too_far ? '0 : lst[SH_W];
      K_SHR:   res = too_far ? '0 : rst_[SH_W];
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/acc_exec_flags.sv
module acc_exec_flags
  import acc_exec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_kind_e          kind,
  input  logic [3:0]        low_nib,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [DATA_W-1:0] acc0,
  input  logic [DATA_W-1:0] acc1,
  input  logic [DATA_W-1:0] res,
  input  logic              carry,
  input  logic              ovf,
  output logic [FLAG_W-1:0] flags_next
);

  logic [DATA_W-1:0] ref_val;
  logic              eq, sgt, ugt, g_en, e_en, is_zero, odd;

  always_comb begin
    ref_val = low_nib[3] ? acc1 : '0;
    eq      = (acc0 == ref_val);
    sgt     = ($signed(acc0) > $signed(ref_val));
    ugt     = (acc0 > ref_val);
    g_en    = low_nib[1];
    e_en    = low_nib[0];
    is_zero = (res == '0);
    odd     = ^res;
    unique case (kind)
      K_ADDI, K_ADD, K_SUB: flags_next = {carry, ovf};
      K_XOR, K_AND, K_OR:   flags_next = {odd, is_zero};
      K_SHL, K_SHR:         flags_next = {res[DATA_W-1], is_zero};
      K_FDEC:               flags_next = {2{low_nib[flags_in]}};
      K_CMP:                flags_next = {(g_en && sgt) || (e_en && eq),
                                          (g_en && ugt) || (e_en && eq)};
      default:              flags_next = flags_in;
    endcase
  end

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        op_i,
  input  logic [DATA_W-1:0] acc0_i,
  input  logic [DATA_W-1:0] acc1_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [1:0]        flags_i,
  output logic [DATA_W-1:0] acc_res_o,
  output logic              acc_we_o,
  output logic              acc_sel_o,
  output logic [1:0]        flags_o
);

  localparam int PAD_W = DATA_W - IMM_W;

  op_kind_e          kind;
  logic              tgt_sel, we_d;
  logic [IMM_W-1:0]  imm;
  logic [DATA_W-1:0] acc_cur, arith_b, sum, bit_res, result;
  logic              carry, ovf;
  logic [FLAG_W-1:0] flags_d;

  acc_exec_decode u_dec (
    .op      (op_i),
    .kind    (kind),
    .tgt_sel (tgt_sel),
    .acc_we  (we_d),
    .imm     (imm)
  );

  assign acc_cur = tgt_sel ? acc1_i : acc0_i;
  assign arith_b = (kind == K_ADDI) ? {{PAD_W{1'b0}}, imm} : reg_i;

  acc_exec_arith #(.DATA_W(DATA_W)) u_arith (
    .a     (acc_cur),
    .b     (arith_b),
    .sub   (kind == K_SUB),
    .sum   (sum),
    .carry (carry),
    .ovf   (ovf)
  );

  acc_exec_bitops #(.DATA_W(DATA_W)) u_bits (
    .kind (kind),
    .a    (acc_cur),
    .b    (reg_i),
    .res  (bit_res)
  );

  assign result = ((kind == K_ADDI) || (kind == K_ADD) || (kind == K_SUB)) ? sum : bit_res;

  acc_exec_flags #(.DATA_W(DATA_W)) u_flags (
    .kind       (kind),
    .low_nib    (op_i[3:0]),
    .flags_in   (flags_i),
    .acc0       (acc0_i),
    .acc1       (acc1_i),
    .res        (result),
    .carry      (carry),
    .ovf        (ovf),
    .flags_next (flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_res_o <= '0;
      acc_we_o  <= 1'b0;
      acc_sel_o <= 1'b0;
      flags_o   <= '0;
    end else begin
      acc_res_o <= we_d ? result : '0;
      acc_we_o  <= we_d;
      acc_sel_o <= we_d & tgt_sel;
      flags_o   <= flags_d;
    end
  end

endmodule

// File: rtl/acc_exec_unit_chk.sv
module acc_exec_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        op_i,
  input logic [DATA_W-1:0] acc0_i,
  input logic [DATA_W-1:0] acc1_i,
  input logic [DATA_W-1:0] reg_i,
  input logic [1:0]        flags_i,
  input logic [DATA_W-1:0] acc_res_o,
  input logic              acc_we_o,
  input logic              acc_sel_o,
  input logic [1:0]        flags_o
);

  logic is_pass, is_shift, is_logic, writes;
  assign is_pass  = (op_i[7:4] == 4'b0110) || (op_i[7:6] == 2'b10);
  assign is_shift = (op_i[7:5] == 3'b111);
  assign is_logic = (op_i[7:4] == 4'b0111) || (op_i[7:5] == 3'b110);
  assign writes   = !is_pass && (op_i[7:4] != 4'b0100) && (op_i[7:4] != 4'b0101);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_res_o == '0) && !acc_we_o && !acc_sel_o && (flags_o == 2'b00));

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_we_o |-> (acc_res_o == '0) && !acc_sel_o);

  // R2
  target_chk: assert property (@(posedge clk) disable iff (rst)
    writes |=> acc_we_o && (acc_sel_o == $past(op_i[3])));

  // R6
  logic_zero_chk: assert property (@(posedge clk) disable iff (rst)
    is_logic |=> (flags_o[0] == (acc_res_o == '0)));

  // R7
  shift_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (is_shift && (reg_i >= DATA_W)) |=> (acc_res_o == '0) && (flags_o == 2'b01));

  // R8
  fdec_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i[7:4] == 4'b0100) |=> !acc_we_o && (flags_o == {2{$past(op_i[flags_i])}}));

  // R9
  cmp_equal_chk: assert property (@(posedge clk) disable iff (rst)
    ((op_i[7:4] == 4'b0101) && op_i[3] && op_i[0] && (acc0_i == acc1_i))
      |=> !acc_we_o && (flags_o == 2'b11));

  // R10
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    is_pass |=> !acc_we_o && (flags_o == $past(flags_i)));

endmodule

bind acc_exec_unit acc_exec_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_i      (op_i),
  .acc0_i    (acc0_i),
  .acc1_i    (acc1_i),
  .reg_i     (reg_i),
  .flags_i   (flags_i),
  .acc_res_o (acc_res_o),
  .acc_we_o  (acc_we_o),
  .acc_sel_o (acc_sel_o),
  .flags_o   (flags_o)
);

// File: tb/acc_exec_unit_tb.sv
module acc_exec_unit_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] op_i = 8'h00, acc0_i = 8'h00, acc1_i = 8'h00, reg_i = 8'h00;
  logic [1:0] flags_i = 2'b00;
  logic [7:0] acc_res_o;
  logic       acc_we_o, acc_sel_o;
  logic [1:0] flags_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  acc_exec_unit u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .acc0_i(acc0_i), .acc1_i(acc1_i),
    .reg_i(reg_i), .flags_i(flags_i), .acc_res_o(acc_res_o),
    .acc_we_o(acc_we_o), .acc_sel_o(acc_sel_o), .flags_o(flags_o)
  );

  // {op, acc0, acc1, reg, flags_in, exp_res, exp_we, exp_sel, exp_flags, req}
  localparam int N = 32;
  localparam logic [53:0] TBL [N] = '{
    {8'h13, 8'h10, 8'h00, 8'h00, 2'b11, 8'h1B, 1'b1, 1'b0, 2'b00, 8'd3},  // R3 imm {b4,b2:0}
    {8'h0F, 8'h00, 8'h7D, 8'h00, 2'b00, 8'h84, 1'b1, 1'b1, 2'b01, 8'd3},  // R3 overflow, acc1
    {8'h21, 8'hF0, 8'h00, 8'h20, 2'b00, 8'h10, 1'b1, 1'b0, 2'b10, 8'd4},  // R4 carry
    {8'h29, 8'h00, 8'h40, 8'h40, 2'b11, 8'h80, 1'b1, 1'b1, 2'b01, 8'd4},  // R4 overflow
    {8'h30, 8'h05, 8'h00, 8'h03, 2'b00, 8'h02, 1'b1, 1'b0, 2'b10, 8'd5},  // R5 no borrow
    {8'h30, 8'h03, 8'h00, 8'h05, 2'b11, 8'hFE, 1'b1, 1'b0, 2'b00, 8'd5},  // R5 borrow
    {8'h38, 8'h00, 8'h80, 8'h01, 2'b00, 8'h7F, 1'b1, 1'b1, 2'b11, 8'd5},  // R5 signed overflow
    {8'h70, 8'hAA, 8'h00, 8'hAA, 2'b00, 8'h00, 1'b1, 1'b0, 2'b01, 8'd6},  // R6 xor zero
    {8'hC0, 8'hF0, 8'h00, 8'h3C, 2'b11, 8'h30, 1'b1, 1'b0, 2'b00, 8'd6},  // R6 and even
    {8'hD8, 8'h00, 8'h01, 8'h06, 2'b00, 8'h07, 1'b1, 1'b1, 2'b10, 8'd6},  // R6 or odd
    {8'hE0, 8'h81, 8'h00, 8'h01, 2'b11, 8'h02, 1'b1, 1'b0, 2'b00, 8'd7},  // R7 left 1
    {8'hE0, 8'h03, 8'h00, 8'h06, 2'b00, 8'hC0, 1'b1, 1'b0, 2'b10, 8'd7},  // R7 sign
    {8'hF8, 8'h00, 8'h80, 8'h07, 2'b00, 8'h01, 1'b1, 1'b1, 2'b00, 8'd7},  // R7 right 7
    {8'hF0, 8'hFF, 8'h00, 8'h08, 2'b00, 8'h00, 1'b1, 1'b0, 2'b01, 8'd7},  // R7 amount 8
    {8'hE0, 8'hFF, 8'h00, 8'hFF, 2'b10, 8'h00, 1'b1, 1'b0, 2'b01, 8'd7},  // R7 amount 255
    {8'hF0, 8'h96, 8'h00, 8'h00, 2'b00, 8'h96, 1'b1, 1'b0, 2'b10, 8'd7},  // R7 amount 0
    {8'h44, 8'h12, 8'h34, 8'h56, 2'b10, 8'h00, 1'b0, 1'b0, 2'b11, 8'd8},  // R8 hit
    {8'h4B, 8'h00, 8'h00, 8'h00, 2'b10, 8'h00, 1'b0, 1'b0, 2'b00, 8'd8},  // R8 miss
    {8'h48, 8'h00, 8'h00, 8'h00, 2'b11, 8'h00, 1'b0, 1'b0, 2'b11, 8'd8},  // R8 index 3
    {8'h41, 8'h00, 8'h00, 8'h00, 2'b00, 8'h00, 1'b0, 1'b0, 2'b11, 8'd8},  // R8 index 0
    {8'h5B, 8'h05, 8'h05, 8'h00, 2'b00, 8'h00, 1'b0, 1'b0, 2'b11, 8'd9},  // R9 equal
    {8'h5A, 8'h80, 8'h01, 8'h00, 2'b00, 8'h00, 1'b0, 1'b0, 2'b01, 8'd9},  // R9 unsigned only
    {8'h5A, 8'h01, 8'h80, 8'h00, 2'b00, 8'h00, 1'b0, 1'b0, 2'b10, 8'd9},  // R9 signed only
    {8'h52, 8'h7F, 8'h7F, 8'h00, 2'b00, 8'h00, 1'b0, 1'b0, 2'b11, 8'd9},  // R9 vs zero
    {8'h55, 8'h00, 8'h09, 8'h00, 2'b00, 8'h00, 1'b0, 1'b0, 2'b11, 8'd9},  // R9 U bit ignored
    {8'h56, 8'hF0, 8'h00, 8'h00, 2'b00, 8'h00, 1'b0, 1'b0, 2'b01, 8'd9},  // R9 negative vs zero
    {8'h5B, 8'h03, 8'h05, 8'h00, 2'b11, 8'h00, 1'b0, 1'b0, 2'b00, 8'd9},  // R9 less
    {8'h6F, 8'h01, 8'h02, 8'h03, 2'b10, 8'h00, 1'b0, 1'b0, 2'b10, 8'd10}, // R10 jump
    {8'h85, 8'h01, 8'h02, 8'h03, 2'b01, 8'h00, 1'b0, 1'b0, 2'b01, 8'd10}, // R10 load
    {8'h93, 8'h01, 8'h02, 8'h03, 2'b11, 8'h00, 1'b0, 1'b0, 2'b11, 8'd10}, // R10 store
    {8'hA0, 8'h01, 8'h02, 8'h03, 2'b00, 8'h00, 1'b0, 1'b0, 2'b00, 8'd10}, // R10 mem load
    {8'hBF, 8'h01, 8'h02, 8'h03, 2'b10, 8'h00, 1'b0, 1'b0, 2'b10, 8'd10}  // R10 mem store
  };

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input int res, input int we, input int sel, input int fl);
    check(tag, "result", acc_res_o, res);
    check(tag, "write", acc_we_o, we);
    check(tag, "target", acc_sel_o, sel);
    check(tag, "flags", flags_o, fl);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state right after reset
    check_all("R1", 0, 0, 0, 0);
    rst = 1'b0;
    for (int i = 0; i < N; i++) begin
      op_i    = TBL[i][53:46];
      acc0_i  = TBL[i][45:38];
      acc1_i  = TBL[i][37:30];
      reg_i   = TBL[i][29:22];
      flags_i = TBL[i][21:20];
      @(negedge clk);
      check_all($sformatf("R%0d", TBL[i][7:0]), TBL[i][19:12], TBL[i][11], TBL[i][10], TBL[i][9:8]);
    end
    // R2: new inputs do not reach the outputs before the next edge
    op_i = 8'h21; acc0_i = 8'h01; reg_i = 8'h01; flags_i = 2'b00;
    #1;
    check_all("R2", 0, 0, 0, 2'b10);
    @(negedge clk);
    check_all("R2", 8'h02, 1, 0, 2'b00);
    // R1: reset mid-run with a writing opcode on the inputs
    rst = 1'b1;
    @(negedge clk);
    check_all("R1", 0, 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check_all("R4", 8'h02, 1, 0, 2'b00);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule